// File: doc/BRIEF.md
# Banked Command and Interrupt Register File

This block is the host-side control front of a small Ethernet controller. A host reaches it over an 8-bit data path with separate active-low read and write strobes and a 4-bit register offset. A command register sits at offset 0 in every bank. Its top two bits pick which bank the other offsets refer to. The same register holds the run/stop control, a remote-DMA command field and a transmit request.

Bank 0 holds the interrupt status register and the interrupt mask register. Bank 1 holds six station-address bytes and the current receive page pointer. Event pulses from the DMA, transmit and receive logic set status flags. The host clears a flag by writing a one to it. Any flag that is both set and enabled drives a single interrupt line. The controller comes out of reset stopped. When a stop request arrives while a frame is in flight, the block waits for that frame to finish before it goes offline.

Top module: `nhr_host_regs`

## Requirements
- R1: After reset the command register reads 0x01, status reads 0x80, mask reads 0x00, `offline` is 1 and `irq` is 0.
- R2: Command bits 7:6 select the bank. The command register is at offset 0 in every bank. In bank 0, offset 1 is status and offset 2 is mask. In bank 1, offsets 1 to 6 are station bytes 0 to 5 and offset 7 is the current page pointer. Every other offset reads 0.
- R3: `host_rdata` carries the addressed register and `host_rdata_oe` is 1 only while `host_rd_n` is low. Otherwise both are 0.
- R4: The block leaves the stopped state only on a command write with bit 0 = 0 and bit 1 = 1. Bit 1 together with bit 0 = 1, or a write with both bits 0, leaves it stopped.
- R5: A command write with bit 0 = 1 while running makes command bit 0 read 1 at once. `offline` rises, and status bit 7 sets, on the first clock edge after the commit at which `link_busy` is low.
- R6: A command write with bit 5 = 1 clears the transmit request (command bit 2) and gives a one-cycle `dma_abort` pulse without a `tx_start` pulse.
- R7: A command write with bit 2 = 1 and bit 5 = 0 while running sets command bit 2 and gives a one-cycle `tx_start` pulse. Bit 2 stays set until `ev_ptx` or `ev_txe`. While stopped, such a write gives no pulse and bit 2 stays 0.
- R8: Each event input sets its status bit: `ev_rdc` bit 6, `ev_cnt` bit 5, `ev_ovw` bit 4, `ev_txe` bit 3, `ev_rxe` bit 2, `ev_ptx` bit 1, `ev_prx` bit 0.
- R9: A bank-0 write to offset 1 clears the status bits written as 1 and leaves the others. 0xFF clears all of them. An event in the same cycle as the clear keeps its bit set.
- R10: Mask bit 7 reads 0. `irq` is the OR over bits 6:0 of status AND mask, so bit 7 never raises `irq`.
- R11: A write commits once per low period of `host_wr_n`, at the first clock edge that sees it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 4 | Register offset within the selected bank |
| host_wdata | input | 8 | Write data |
| host_rd_n | input | 1 | Active-low read strobe |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rdata | output | 8 | Read data, zero when not reading |
| host_rdata_oe | output | 1 | Read data valid / drive enable |
| link_busy | input | 1 | A frame is being sent or received |
| ev_rdc | input | 1 | Remote DMA complete pulse |
| ev_cnt | input | 1 | Counter overflow pulse |
| ev_ovw | input | 1 | Receive ring overwrite pulse |
| ev_txe | input | 1 | Transmit error pulse |
| ev_rxe | input | 1 | Receive error pulse |
| ev_ptx | input | 1 | Transmit done pulse |
| ev_prx | input | 1 | Frame received pulse |
| irq | output | 1 | Interrupt request |
| tx_start | output | 1 | One-cycle transmit start |
| dma_abort | output | 1 | One-cycle remote DMA abort |
| offline | output | 1 | Controller in the stopped state |

## Verification
The bench holds a stop request against a busy link. A design that goes offline at once, or that sets the reset flag before the frame ends, is caught there. It also drives an event in the same cycle as its clear, and a design that gives the clear priority loses the flag. A write held for several cycles while an event arrives shows whether a design commits on every low cycle, because such a design wipes the new flag. Start writes that also set the stop bit, transmit requests while stopped, and an abort after a pending transmit each expose a design that ignores the start/stop rule or fails to drop the request.

// File: rtl/nhr_pkg.sv
package nhr_pkg;
  typedef enum logic [1:0] {
    RS_STOP  = 2'd0,
    RS_RUN   = 2'd1,
    RS_DRAIN = 2'd2
  } run_e;

  localparam int OFS_CMD  = 0;
  localparam int OFS_IST  = 1;
  localparam int OFS_IMK  = 2;
  localparam int OFS_CUR  = 7;
  localparam int OFS_STA0 = 1;

  localparam logic [7:0] IST_RESET = 8'h80;
  localparam logic [7:0] CMD_RESET = 8'h01;

  // Next status value: write-one-to-clear, then new events win
  function automatic logic [7:0] w1c_next(input logic [7:0] cur,
                                          input logic [7:0] clr,
                                          input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

  // Interrupt request from status and mask; bit 7 never participates
  function automatic logic irq_of(input logic [7:0] st, input logic [7:0] mk);
    return |(st[6:0] & mk[6:0]);
  endfunction
endpackage

// File: rtl/nhr_wstrobe.sv
module nhr_wstrobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic commit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= wr_n;
  end

  assign commit = !wr_n && prev_q;
endmodule

// File: rtl/nhr_cmd.sv
module nhr_cmd
  import nhr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          link_busy,
  input  logic          tx_done,
  output logic [1:0]    page,
  output logic [DW-1:0] cmd_value,
  output logic          tx_start,
  output logic          dma_abort,
  output logic          stop_entry,
  output logic          offline
);
  run_e       state_q;
  logic [1:0] ps_q;
  logic [2:0] rd_q;
  logic       sta_q, txp_q, txs_q, abt_q;
  logic       start_wr, drain_done;

  assign start_wr   = wr_cmd && !wdata[0] && wdata[1];
  assign drain_done = (state_q == RS_DRAIN) && !link_busy;
  assign stop_entry = drain_done && !start_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_STOP;
      ps_q    <= 2'b00;
      rd_q    <= 3'b000;
      sta_q   <= 1'b0;
      txp_q   <= 1'b0;
      txs_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      txs_q <= 1'b0;
      abt_q <= 1'b0;
      if (tx_done) txp_q <= 1'b0;
      if (stop_entry) state_q <= RS_STOP;
      if (wr_cmd) begin
        ps_q  <= wdata[7:6];
        rd_q  <= wdata[5:3];
        sta_q <= wdata[1];
        if (wdata[5]) begin
          txp_q <= 1'b0;
          abt_q <= 1'b1;
        end else if (wdata[2] && state_q == RS_RUN) begin
          txp_q <= 1'b1;
          txs_q <= 1'b1;
        end
        if (wdata[0]) begin
          if (state_q == RS_RUN) state_q <= RS_DRAIN;
        end else if (wdata[1]) begin
          state_q <= RS_RUN;
        end
      end
    end
  end

  assign page      = ps_q;
  assign cmd_value = {ps_q, rd_q, txp_q, sta_q, state_q != RS_RUN};
  assign tx_start  = txs_q;
  assign dma_abort = abt_q;
  assign offline   = (state_q == RS_STOP);
endmodule

// File: rtl/nhr_intr.sv
module nhr_intr
  import nhr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ist,
  input  logic          wr_imk,
  input  logic [DW-1:0] wdata,
  input  logic [6:0]    events,
  input  logic          stop_entry,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic          irq
);
  logic [DW-1:0] st_q, mk_q, set_v, clr_v;

  assign set_v = {stop_entry, events};
  assign clr_v = wr_ist ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= IST_RESET;
      mk_q <= '0;
    end else begin
      st_q <= w1c_next(st_q, clr_v, set_v);
      if (wr_imk) mk_q <= {1'b0, wdata[6:0]};
    end
  end

  assign status = st_q;
  assign mask   = mk_q;
  assign irq    = irq_of(st_q, mk_q);
endmodule

// File: rtl/nhr_page1.sv
module nhr_page1
  import nhr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int N_STATION = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] sta_q [N_STATION];
  logic [DW-1:0] cur_q;
  logic [DW-1:0] sel [N_STATION];

  for (genvar i = 0; i < N_STATION; i++) begin : g_sta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sta_q[i] <= '0;
      else if (wr_en && addr == AW'(OFS_STA0 + i)) sta_q[i] <= wdata;
    end
    if (i == 0) begin : g_first
      assign sel[i] = (addr == AW'(OFS_STA0 + i)) ? sta_q[i] : '0;
    end else begin : g_rest
      assign sel[i] = sel[i-1] | ((addr == AW'(OFS_STA0 + i)) ? sta_q[i] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (wr_en && addr == AW'(OFS_CUR)) cur_q <= wdata;
  end

  assign rdata = sel[N_STATION-1] | ((addr == AW'(OFS_CUR)) ? cur_q : '0);
endmodule

// File: rtl/nhr_host_regs.sv
module nhr_host_regs
  import nhr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int N_STATION = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  input  logic          link_busy,
  input  logic          ev_rdc,
  input  logic          ev_cnt,
  input  logic          ev_ovw,
  input  logic          ev_txe,
  input  logic          ev_rxe,
  input  logic          ev_ptx,
  input  logic          ev_prx,
  output logic          irq,
  output logic          tx_start,
  output logic          dma_abort,
  output logic          offline
);
  logic          wr_commit, stop_entry;
  logic          wr_cmd, wr_ist, wr_imk, wr_p1;
  logic [1:0]    pg;
  logic [DW-1:0] cmd_v, st_q, mk_q, p1_rd;
  logic [DW-1:0] rd_mux;
  logic [6:0]    ev_vec;

  assign ev_vec = {ev_rdc, ev_cnt, ev_ovw, ev_txe, ev_rxe, ev_ptx, ev_prx};

  nhr_wstrobe u_wstb (
    .clk(clk), .rst_n(rst_n), .wr_n(host_wr_n), .commit(wr_commit)
  );

  assign wr_cmd = wr_commit && host_addr == AW'(OFS_CMD);
  assign wr_ist = wr_commit && pg == 2'd0 && host_addr == AW'(OFS_IST);
  assign wr_imk = wr_commit && pg == 2'd0 && host_addr == AW'(OFS_IMK);
  assign wr_p1  = wr_commit && pg == 2'd1;

  nhr_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(host_wdata),
    .link_busy(link_busy), .tx_done(ev_ptx | ev_txe),
    .page(pg), .cmd_value(cmd_v), .tx_start(tx_start),
    .dma_abort(dma_abort), .stop_entry(stop_entry), .offline(offline)
  );

  nhr_intr #(.DW(DW)) u_intr (
    .clk(clk), .rst_n(rst_n), .wr_ist(wr_ist), .wr_imk(wr_imk),
    .wdata(host_wdata), .events(ev_vec), .stop_entry(stop_entry),
    .status(st_q), .mask(mk_q), .irq(irq)
  );

  nhr_page1 #(.DW(DW), .AW(AW), .N_STATION(N_STATION)) u_p1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_p1), .addr(host_addr),
    .wdata(host_wdata), .rdata(p1_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (host_addr == AW'(OFS_CMD)) begin
      rd_mux = cmd_v;
    end else begin
      case (pg)
        2'd0: begin
          if (host_addr == AW'(OFS_IST))      rd_mux = st_q;
          else if (host_addr == AW'(OFS_IMK)) rd_mux = mk_q;
        end
        2'd1:    rd_mux = p1_rd;
        default: rd_mux = '0;
      endcase
    end
  end

  assign host_rdata_oe = !host_rd_n;
  assign host_rdata    = host_rd_n ? '0 : rd_mux;
endmodule

// File: rtl/nhr_host_regs_chk.sv
module nhr_host_regs_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd_n,
  input logic [DW-1:0] host_rdata,
  input logic          host_rdata_oe,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          wr_commit,
  input logic          stop_entry,
  input logic [DW-1:0] st_q,
  input logic [DW-1:0] mk_q,
  input logic          tx_start,
  input logic          dma_abort,
  input logic          offline,
  input logic          irq
);
  a_r3_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_n |-> (host_rdata == '0 && !host_rdata_oe));

  a_r4_stop_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (offline && wr_commit && host_addr == '0 && host_wdata[0]) |=> offline);

  a_r5_rst_flag_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_entry |=> st_q[7]);

  a_r6_abort_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    dma_abort |-> !tx_start);

  a_r7_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r7_no_tx_offline: assert property (@(posedge clk) disable iff (!rst_n)
    offline |=> !tx_start);

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mk_q[6:0] == '0) |-> !irq);
endmodule

bind nhr_host_regs nhr_host_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_rdata(host_rdata),
  .host_rdata_oe(host_rdata_oe), .host_addr(host_addr), .host_wdata(host_wdata),
  .wr_commit(wr_commit), .stop_entry(stop_entry), .st_q(st_q), .mk_q(mk_q),
  .tx_start(tx_start), .dma_abort(dma_abort), .offline(offline), .irq(irq)
);

// File: tb/sim_nhr_host_regs.sv
module sim_nhr_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
  logic [7:0] host_rdata;
  logic       host_rdata_oe;
  logic       link_busy = 1'b0;
  logic [6:0] ev = '0;
  logic       irq, tx_start, dma_abort, offline;

  int n_chk = 0, n_bad = 0;
  logic seen_tx, seen_abt;

  always #5 clk = ~clk;

  nhr_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_rdata(host_rdata),
    .host_rdata_oe(host_rdata_oe), .link_busy(link_busy),
    .ev_rdc(ev[6]), .ev_cnt(ev[5]), .ev_ovw(ev[4]), .ev_txe(ev[3]),
    .ev_rxe(ev[2]), .ev_ptx(ev[1]), .ev_prx(ev[0]),
    .irq(irq), .tx_start(tx_start), .dma_abort(dma_abort), .offline(offline)
  );

  // {op, req, addr, data, expected}; op 0 write, 1 read-check, 2 event pulse
  localparam logic [25:0] VECS [0:20] = '{
    {2'd1, 4'd1,  4'h0, 8'h00, 8'h01},  // R1 cmd reset
    {2'd1, 4'd1,  4'h1, 8'h00, 8'h80},  // R1 status reset
    {2'd1, 4'd1,  4'h2, 8'h00, 8'h00},  // R1 mask reset
    {2'd0, 4'd10, 4'h2, 8'hFF, 8'h00},
    {2'd1, 4'd10, 4'h2, 8'h00, 8'h7F},  // R10 mask bit 7 reads 0
    {2'd0, 4'd4,  4'h0, 8'h02, 8'h00},
    {2'd1, 4'd4,  4'h0, 8'h00, 8'h02},  // R4 running
    {2'd2, 4'd8,  4'h0, 8'h41, 8'h00},
    {2'd1, 4'd8,  4'h1, 8'h00, 8'hC1},  // R8 rdc + prx set
    {2'd0, 4'd9,  4'h1, 8'h81, 8'h00},
    {2'd1, 4'd9,  4'h1, 8'h00, 8'h40},  // R9 partial clear
    {2'd0, 4'd9,  4'h1, 8'hFF, 8'h00},
    {2'd1, 4'd9,  4'h1, 8'h00, 8'h00},  // R9 full clear
    {2'd0, 4'd2,  4'h0, 8'h42, 8'h00},
    {2'd0, 4'd2,  4'h3, 8'hA5, 8'h00},
    {2'd0, 4'd2,  4'h7, 8'h46, 8'h00},
    {2'd1, 4'd2,  4'h3, 8'h00, 8'hA5},  // R2 station byte 2
    {2'd1, 4'd2,  4'h7, 8'h00, 8'h46},  // R2 current page pointer
    {2'd1, 4'd2,  4'h1, 8'h00, 8'h00},  // R2 station byte 0 untouched
    {2'd0, 4'd2,  4'h0, 8'h02, 8'h00},
    {2'd1, 4'd2,  4'h3, 8'h00, 8'h00}   // R2 bank 0 unmapped offset
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_n = 1'b0;
    @(negedge clk);
    host_wr_n = 1'b1;
    seen_tx = tx_start; seen_abt = dma_abort;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd_n = 1'b0;
    #1 d = host_rdata;
    host_rd_n = 1'b1;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 offline", {7'd0, offline}, 8'h01);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    foreach (VECS[i]) begin
      case (VECS[i][25:24])
        2'd0: wr(VECS[i][19:16], VECS[i][15:8]);
        2'd1: begin
          rd(VECS[i][19:16], r);
          chk($sformatf("R%0d vec%0d", VECS[i][23:20], i), r, VECS[i][7:0]);
        end
        default: pulse(VECS[i][14:8]);
      endcase
    end

    // R3: no read strobe, nothing driven
    @(negedge clk); host_addr = 4'h0;
    #1 chk("R3 idle data", host_rdata, 8'h00);
    chk("R3 idle oe", {7'd0, host_rdata_oe}, 8'h00);

    // R11: held write commits once; event arriving mid-hold survives
    @(negedge clk);
    host_addr = 4'h1; host_wdata = 8'h01; host_wr_n = 1'b0;
    @(negedge clk); ev = 7'h01;
    @(negedge clk); ev = '0;
    @(negedge clk); host_wr_n = 1'b1;
    rd(4'h1, r); chk("R11 held write once", r, 8'h01);
    chk("R10 irq enabled flag", {7'd0, irq}, 8'h01);

    // R9: set wins over same-cycle clear
    wr(4'h1, 8'hFF);
    @(negedge clk);
    host_addr = 4'h1; host_wdata = 8'h04; host_wr_n = 1'b0; ev = 7'h04;
    @(negedge clk); host_wr_n = 1'b1; ev = '0;
    rd(4'h1, r); chk("R9 set beats clear", r, 8'h04);
    wr(4'h2, 8'h00);
    @(negedge clk); chk("R10 masked irq", {7'd0, irq}, 8'h00);
    wr(4'h1, 8'hFF);

    // R7: transmit while running
    wr(4'h0, 8'h06);
    chk("R7 tx pulse", {7'd0, seen_tx}, 8'h01);
    @(negedge clk); chk("R7 tx one cycle", {7'd0, tx_start}, 8'h00);
    rd(4'h0, r); chk("R7 txp held", r, 8'h06);
    pulse(7'h02);
    rd(4'h0, r); chk("R7 txp cleared by done", r, 8'h02);

    // R6: abort drops pending request
    wr(4'h0, 8'h06);
    wr(4'h0, 8'h22);
    chk("R6 abort pulse", {7'd0, seen_abt}, 8'h01);
    chk("R6 no tx on abort", {7'd0, seen_tx}, 8'h00);
    rd(4'h0, r); chk("R6 txp cleared", r, 8'h22);
    wr(4'h1, 8'hFF);

    // R5: stop waits for busy link
    @(negedge clk); link_busy = 1'b1;
    wr(4'h0, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 still online while busy", {7'd0, offline}, 8'h00);
    rd(4'h0, r); chk("R5 stop bit reads 1", r, 8'h01);
    rd(4'h1, r); chk("R5 no reset flag yet", r, 8'h00);
    link_busy = 1'b0;
    @(negedge clk);
    chk("R5 offline after drain", {7'd0, offline}, 8'h01);
    rd(4'h1, r); chk("R5 reset flag set", r, 8'h80);
    wr(4'h2, 8'h7F);
    @(negedge clk); chk("R10 reset flag no irq", {7'd0, irq}, 8'h00);

    // R7 while stopped
    wr(4'h0, 8'h05);
    chk("R7 no tx offline", {7'd0, seen_tx}, 8'h00);
    rd(4'h0, r); chk("R7 txp stays 0 offline", r, 8'h01);

    // R4: start rules
    wr(4'h0, 8'h03);
    @(negedge clk); chk("R4 start with stop", {7'd0, offline}, 8'h01);
    wr(4'h0, 8'h00);
    @(negedge clk); chk("R4 clear without start", {7'd0, offline}, 8'h01);
    wr(4'h0, 8'h02);
    @(negedge clk); chk("R4 proper start", {7'd0, offline}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule